// File: doc/BRIEF.md
# SPI Target Hold-Pause Serial Front End

This block is the serial edge of an SPI target. It oversamples chip select, serial clock, the active-low pause input and serial data with a faster system clock. It receives mode-0 bytes MSB first and drives an output shift path.

It also decides when a pause starts and when it stops. The decision depends on the serial clock level at the moment the pause input moves. While paused, the shift state is frozen, clock and data activity is dropped, and the serial output is released. Releasing chip select during a pause returns the serial logic to idle.

An internal busy flag from the array side passes straight through and is not affected by a pause. A quad-mode flag disables the pause input.

The system clock must run at least four times the serial clock rate.

Top module: `spi_hold_frontend`

## Requirements
- R1: With chip select low and no pause, `si` is sampled on each rising `sck`, MSB first. After the eighth rising edge, `rx_byte` takes the received byte and `rx_valid` is high for exactly one system clock. `rx_byte` keeps its value until the next complete byte.
- R2: While `cs_n` is high, the output shifter loads `tx_data`. Bit 7 appears on `so` before the first rising `sck`. Each falling `sck` moves the next lower bit onto `so`. The falling edge after the eighth bit loads `tx_data` as it stands at that moment.
- R3: `so_oe` is 1 while `cs_n` is low and no pause is active. It is 0 while `cs_n` is high.
- R4: If `hold_n` falls while `sck` is low, `hold_active` rises within a few system clocks and `so_oe` goes to 0.
- R5: If `hold_n` falls while `sck` is high, the pause waits. It begins at the next falling `sck`, and that falling edge still shifts the output. If `hold_n` returns high before that falling edge, no pause occurs.
- R6: If `hold_n` rises while `sck` is low, the pause ends at once. If it rises while `sck` is high, the pause lasts until the next falling `sck`, and that falling edge does not shift.
- R7: During a pause, `sck` and `si` transitions are ignored. No bit is counted and no output bit moves. The byte in progress completes correctly after the pause.
- R8: `cs_n` high clears the bit counter, the shift registers and any pause. The next byte after chip select falls again starts at bit 7.
- R9: While `quad_en` is 1, `hold_n` has no effect: `hold_active` stays 0 and bytes transfer normally.
- R10: `busy_out` equals `busy_in` delayed by one system clock, whether or not a pause is active.
- R11: After reset, `hold_active`, `so_oe`, `rx_valid` and `rx_byte` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock pin |
| cs_n | input | 1 | Chip select pin, active low |
| hold_n | input | 1 | Pause request pin, active low |
| si | input | 1 | Serial data in |
| quad_en | input | 1 | Quad mode enabled; disables the pause pin |
| busy_in | input | 1 | Internal operation-in-progress flag |
| tx_data | input | DATA_W | Next byte to shift out |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for `so` (0 = high impedance) |
| rx_byte | output | DATA_W | Last complete received byte |
| rx_valid | output | 1 | One-clock strobe for a new `rx_byte` |
| hold_active | output | 1 | Pause in effect |
| busy_out | output | 1 | Busy flag, independent of pause |

## Verification
The hard cases are a pause-pin change and a serial clock falling edge that take effect in the same system cycle. On entry, the bench lowers `hold_n` while `sck` is high and then drops `sck`. On exit, it raises `hold_n` while `sck` is high and then drops `sck`. The judgement comes from the output bit seen at the next sample and from the received byte: the entry edge must shift and the exit edge must not. The second collision is chip select rising while a pause is held. The bench then checks that the pause clears and that the next byte is received from bit 7 onward.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int PIN_W = 4;
  // pin vector order: {sck, cs_n, hold_n, si}
  localparam logic [PIN_W-1:0] PIN_IDLE = 4'b0110;
  localparam int P_SCK  = 3;
  localparam int P_CS   = 2;
  localparam int P_HOLD = 1;
  localparam int P_SI   = 0;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[gi] <= RST_VAL;
        else        stg[gi] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[gi] <= RST_VAL;
        else        stg[gi] <= stg[gi-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_lvl,
  input  logic cs_high,
  input  logic hold_n_lvl,
  input  logic quad_en,
  output logic hold_active
);
  logic hold_req;
  logic hold_n_next;

  assign hold_req = ~quad_en & ~hold_n_lvl;

  // pause state follows the request only while sck is low
  always_comb begin
    hold_n_next = hold_active;
    if (cs_high || quad_en) hold_n_next = 1'b0;
    else if (!sck_lvl)      hold_n_next = hold_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_active <= 1'b0;
    else        hold_active <= hold_n_next;
  end

  assert_quad_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    quad_en |=> !hold_active);
  assert_sck_high_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_high && !quad_en && sck_lvl) |=> $stable(hold_active));
  assert_cs_drops_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> !hold_active);
endmodule

// File: rtl/spi_hold_shift.sv
module spi_hold_shift #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_lvl,
  input  logic              si_lvl,
  input  logic              cs_high,
  input  logic              hold_active,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              so_bit
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              sck_prev;
  logic              sck_rise, sck_fall;
  logic [CNT_W-1:0]  cnt, cnt_nx;
  logic [DATA_W-2:0] rsr, rsr_nx;
  logic [DATA_W-1:0] rbyte_nx;
  logic [DATA_W-1:0] tsr, tsr_nx;
  logic              rv_nx;

  assign sck_rise = sck_lvl & ~sck_prev;
  assign sck_fall = ~sck_lvl & sck_prev;

  always_comb begin
    cnt_nx   = cnt;
    rsr_nx   = rsr;
    rbyte_nx = rx_byte;
    tsr_nx   = tsr;
    rv_nx    = 1'b0;
    if (cs_high) begin
      cnt_nx = '0;
      rsr_nx = '0;
      tsr_nx = tx_data;
    end else if (!hold_active) begin
      if (sck_rise) begin
        rsr_nx = {rsr[DATA_W-3:0], si_lvl};
        cnt_nx = cnt + 1'b1;
        if (cnt == LAST_BIT) begin
          rbyte_nx = {rsr, si_lvl};
          rv_nx    = 1'b1;
        end
      end
      if (sck_fall) begin
        if (cnt == '0) tsr_nx = tx_data;
        else           tsr_nx = {tsr[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      cnt      <= '0;
      rsr      <= '0;
      rx_byte  <= '0;
      tsr      <= '0;
      rx_valid <= 1'b0;
    end else begin
      sck_prev <= sck_lvl;
      cnt      <= cnt_nx;
      rsr      <= rsr_nx;
      rx_byte  <= rbyte_nx;
      tsr      <= tsr_nx;
      rx_valid <= rv_nx;
    end
  end

  assign so_bit = tsr[DATA_W-1];

  assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && !cs_high) |=> ($stable(cnt) && $stable(tsr) && !rx_valid));
  assert_cs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> (cnt == '0));
  assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              si,
  input  logic              quad_en,
  input  logic              busy_in,
  input  logic [DATA_W-1:0] tx_data,
  output logic              so,
  output logic              so_oe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              hold_active,
  output logic              busy_out
);
  import spi_hold_pkg::*;

  logic [PIN_W-1:0] pins_raw, pins_s;
  logic             cs_high;

  assign pins_raw = {sck, cs_n, hold_n, si};

  spi_hold_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s));

  assign cs_high = pins_s[P_CS];

  spi_hold_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sck_lvl(pins_s[P_SCK]), .cs_high(cs_high),
    .hold_n_lvl(pins_s[P_HOLD]), .quad_en(quad_en), .hold_active(hold_active));

  spi_hold_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sck_lvl(pins_s[P_SCK]), .si_lvl(pins_s[P_SI]),
    .cs_high(cs_high), .hold_active(hold_active), .tx_data(tx_data),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .so_bit(so));

  assign so_oe = ~cs_high & ~hold_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_out <= 1'b0;
    else        busy_out <= busy_in;
  end

  assert_no_rx_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !hold_active);
  assert_busy_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_out == $past(busy_in));
endmodule

// File: tb/sim_spi_hold_frontend.sv
module sim_spi_hold_frontend;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
  logic quad_en = 1'b0, busy_in = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic so, so_oe, rx_valid, hold_active, busy_out;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0, vcount = 0;
  logic [7:0] last_rx = 8'h00;
  bit done = 0;

  always #4 clk = ~clk;

  spi_hold_frontend u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
    .quad_en(quad_en), .busy_in(busy_in), .tx_data(tx_data), .so(so), .so_oe(so_oe),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .hold_active(hold_active), .busy_out(busy_out));

  always @(negedge clk) if (rx_valid) begin vcount++; last_rx = rx_byte; end

  function automatic logic msb_bit(input logic [7:0] b, input int i);
    return b[7-i];
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic garbage_clock(input int n);
    for (int k = 0; k < n; k++) begin
      si = 1'($urandom_range(1));
      sck = ~sck;
      wclk(HALF);
    end
  endtask

  // kind: 0 none, 1 entry with sck low, 2 entry/exit with sck high, 3 cancelled entry
  task automatic xfer_byte(input logic [7:0] mosi, input logic [7:0] exp_so,
                           input logic [7:0] next_tx, input int kind, input int hold_at);
    logic [7:0] got;
    int v0;
    v0 = vcount;
    got = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (kind == 1 && i == hold_at) begin
        hold_n = 1'b0;
        wclk(HALF);
        chk(hold_active == 1'b1 && so_oe == 1'b0, "R4 hold entry sck low", hold_active, 1);
        busy_in = ~busy_in;
        garbage_clock(2);
        chk(busy_out == busy_in, "R10 busy during hold", busy_out, busy_in);
        hold_n = 1'b1;
        wclk(HALF);
        chk(hold_active == 1'b0, "R6 hold exit sck low", hold_active, 0);
      end
      if (i == 3) tx_data = next_tx;
      si = msb_bit(mosi, i);
      wclk(HALF);
      got[7-i] = so;
      chk(so_oe == 1'b1, "R3 so_oe in frame", so_oe, 1);
      sck = 1'b1;
      wclk(HALF);
      if (kind == 2 && i == hold_at) begin
        hold_n = 1'b0;
        wclk(HALF);
        chk(hold_active == 1'b0, "R5 entry pending while sck high", hold_active, 0);
        sck = 1'b0;
        wclk(HALF);
        chk(hold_active == 1'b1 && so_oe == 1'b0, "R5 entry at sck fall", hold_active, 1);
        garbage_clock(3);
        hold_n = 1'b1;
        wclk(HALF);
        chk(hold_active == 1'b1, "R6 exit pending while sck high", hold_active, 1);
        sck = 1'b0;
        wclk(HALF);
        chk(hold_active == 1'b0, "R6 exit at sck fall", hold_active, 0);
      end else if (kind == 3 && i == hold_at) begin
        hold_n = 1'b0;
        wclk(3);
        hold_n = 1'b1;
        wclk(HALF);
        sck = 1'b0;
        wclk(HALF);
        chk(hold_active == 1'b0, "R5 cancelled entry", hold_active, 0);
      end else begin
        sck = 1'b0;
      end
    end
    wclk(2);
    chk(vcount == v0 + 1 && last_rx == mosi, "R1 R7 received byte", last_rx, mosi);
    chk(got == exp_so, "R2 R7 shifted out byte", got, exp_so);
  endtask

  initial begin
    logic [7:0] a, b, m;
    int nb, kind, hat, v0;
    void'($urandom(32'd20240611));
    wclk(3);
    chk(hold_active == 1'b0 && so_oe == 1'b0, "R11 reset outputs", {hold_active, so_oe}, 0);
    chk(rx_valid == 1'b0 && rx_byte == 8'h00, "R11 reset rx", rx_byte, 0);
    rst_n = 1'b1;
    wclk(4);
    chk(so_oe == 1'b0, "R3 so_oe with cs high", so_oe, 0);

    // two bytes, tx_data changed mid first byte
    tx_data = 8'hA5; wclk(4);
    cs_n = 1'b0; wclk(HALF);
    xfer_byte(8'h3C, 8'hA5, 8'h5A, 0, 0);
    xfer_byte(8'hC3, 8'h5A, 8'h5A, 0, 0);
    cs_n = 1'b1; wclk(HALF);

    // directed pauses
    tx_data = 8'h96; wclk(4);
    cs_n = 1'b0; wclk(HALF);
    xfer_byte(8'h81, 8'h96, 8'h69, 1, 4);
    xfer_byte(8'h7E, 8'h69, 8'hF0, 2, 2);
    xfer_byte(8'h55, 8'hF0, 8'h0F, 3, 5);
    cs_n = 1'b1; wclk(HALF);

    // chip select released during a pause
    tx_data = 8'hE1; wclk(4);
    cs_n = 1'b0; wclk(HALF);
    v0 = vcount;
    for (int i = 0; i < 3; i++) begin
      si = 1'b1; wclk(HALF); sck = 1'b1; wclk(HALF); sck = 1'b0;
    end
    wclk(HALF);
    hold_n = 1'b0; wclk(HALF);
    chk(hold_active == 1'b1, "R8 pause before cs release", hold_active, 1);
    cs_n = 1'b1; wclk(HALF);
    chk(hold_active == 1'b0 && so_oe == 1'b0, "R8 cs release clears pause", hold_active, 0);
    hold_n = 1'b1; wclk(HALF);
    cs_n = 1'b0; wclk(HALF);
    xfer_byte(8'h24, 8'hE1, 8'hE1, 0, 0);
    chk(vcount == v0 + 1, "R8 partial byte discarded", vcount - v0, 1);
    cs_n = 1'b1; wclk(HALF);

    // quad mode ignores the pause pin
    quad_en = 1'b1; tx_data = 8'h3F; wclk(4);
    cs_n = 1'b0; hold_n = 1'b0; wclk(HALF);
    chk(hold_active == 1'b0, "R9 quad ignores pause pin", hold_active, 0);
    xfer_byte(8'hB7, 8'h3F, 8'h3F, 0, 0);
    chk(hold_active == 1'b0, "R9 quad after byte", hold_active, 0);
    cs_n = 1'b1; hold_n = 1'b1; quad_en = 1'b0; wclk(HALF);

    // random frames
    for (int f = 0; f < 60; f++) begin
      a = 8'($urandom);
      tx_data = a; wclk(4);
      cs_n = 1'b0; wclk(HALF);
      nb = $urandom_range(1, 3);
      for (int j = 0; j < nb; j++) begin
        m = 8'($urandom);
        b = 8'($urandom);
        kind = $urandom_range(0, 3);
        hat = $urandom_range(0, 6);
        xfer_byte(m, a, b, kind, hat);
        a = b;
      end
      cs_n = 1'b1; wclk(HALF);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule